// File: doc/BRIEF.md
# Dual-Bank Keyed Flash Erase Register Front End

This block is the register-level front end of an embedded flash controller with two banks. A simple single-cycle 32-bit register bus reaches four registers per bank: a key register, a control register, a status register and a status-clear register. Each bank's control register comes out of reset locked. It can be changed only after software writes two fixed key words to that bank's key register, in the right order. Software can relock a bank by setting the lock bit.

Once a bank is unlocked, software issues a sector erase by writing the control register with the erase-select bit, a non-zero parallelism size, a local sector number and the start bit. The front end checks the request. It then either launches the erase or records an error flag. The status register reports the flags and a single prioritised error code. The flash array is modelled by a fixed-latency busy counter per bank. Each launch is announced on a one-cycle pulse that carries the global sector number: bank index times sectors-per-bank, plus the local index.

Register word addresses: bit 2 selects the bank (0 covers global sectors 0..7, 1 covers 8..15). Bits 1:0 select key (0), control (1), status (2) or clear (3). Key and clear registers read as zero.

Top module: `flc_keyed_regs`

## Requirements
- R1: After reset, each bank's control register reads 0x1 (lock bit 0 set, erase-select bit 1 clear, parallelism bits 5:4 zero, sector bits 10:8 zero). Each status register reads 0, and neither bank is busy.
- R2: While a bank is locked, a control write leaves that bank's control fields unchanged, and the bank stays locked.
- R3: Writing 0x45670123 and then 0xCDEF89AB to a bank's key register clears that bank's lock bit only. The other bank stays locked.
- R4: A key write of any other value, or of the right values in the wrong order, disables unlocking for that bank until the next reset. A later correct pair has no effect.
- R5: Writing a control word with bit 0 set relocks an unlocked bank. The key pair then unlocks it again.
- R6: A start (control bit 2) on an unlocked, idle bank is accepted when erase-select is 1, parallelism is non-zero and the sector is not write-protected. On acceptance, busy is high for exactly ERASE_CYCLES cycles, starting the cycle after the write. A one-cycle launch pulse also appears in that first cycle, with global sector = bank*8 + local sector.
- R7: The erase-select bit is still set in the control register after the erase completes, until software writes it to 0.
- R8: A start while the bank is locked, while it is busy, or with erase-select 0 launches nothing and sets the sequence-error flag (status bit 1).
- R9: A start with parallelism field 0 launches nothing and sets the parallelism-error flag (status bit 2).
- R10: A start on a write-protected sector launches nothing and sets the write-protect flag (status bit 3). By default, global sectors 7 and 14 are write-protected.
- R11: The status error code (bits 9:8) reports the highest-priority pending flag: write-protect gives 1, parallelism gives 2, sequence gives 3, and none gives 0.
- R12: Writing 0xFFFFFFFF to a bank's clear register clears all of that bank's error flags. Any other value leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address: bit 2 bank, bits 1:0 register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| bank_busy | output | 2 | Per-bank erase in progress |
| erase_go | output | 1 | One-cycle erase launch pulse |
| erase_sec | output | 4 | Global sector of the launch, zero when idle |

## Verification
The key sequence is driven with:
- the correct pair, which separates unlocking from the lock bit merely being written;
- the pair reversed, which separates an ordered check from a set-membership check;
- the correct pair again after a failure, which shows the dead state is sticky.

Start requests are issued in the following cases, so that each rejection reason is told apart and each sets its own flag:
- on a locked bank;
- with erase-select clear;
- with zero parallelism;
- on a protected sector;
- on a busy bank;
- a valid request.

Flags are also stacked in different combinations to separate the priority order. A reset in the middle of the run, followed by an erase on bank 2, checks both the reset recovery of the key logic and the sector offset into the upper bank.

// File: rtl/flc_pkg.sv
package flc_pkg;

    localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

    // control register bit positions
    localparam int CB_LOCK  = 0;
    localparam int CB_SER   = 1;
    localparam int CB_START = 2;
    localparam int CB_PS_LO = 4;
    localparam int CB_SN_LO = 8;

    // status register bit positions
    localparam int SB_BUSY    = 0;
    localparam int SB_SEQ     = 1;
    localparam int SB_PAR     = 2;
    localparam int SB_WP      = 3;
    localparam int SB_CODE_LO = 8;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_HALF = 2'd1,
        KS_DEAD = 2'd2
    } key_st_e;

    typedef enum logic [1:0] {
        EC_NONE = 2'd0,
        EC_WP   = 2'd1,
        EC_PAR  = 2'd2,
        EC_SEQ  = 2'd3
    } err_code_e;

    typedef struct packed {
        logic wp;
        logic par;
        logic seq;
    } err_flags_t;

endpackage

// File: rtl/flc_err_prio.sv
module flc_err_prio
    import flc_pkg::*;
(
    input  err_flags_t flags,
    output err_code_e  code
);

    always_comb begin
        if (flags.wp)       code = EC_WP;
        else if (flags.par) code = EC_PAR;
        else if (flags.seq) code = EC_SEQ;
        else                code = EC_NONE;
    end

endmodule

// File: rtl/flc_bank.sv
module flc_bank
    import flc_pkg::*;
#(
    parameter int             SPB          = 8,
    parameter int             ERASE_CYCLES = 20,
    parameter logic [SPB-1:0] WP_BITS      = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_we,
    input  logic              ctrl_we,
    input  logic              clr_we,
    input  logic [31:0]       wdata,
    output logic [31:0]       ctrl_rd,
    output logic [31:0]       stat_rd,
    output logic              busy,
    output logic              go,
    output logic [$clog2(SPB)-1:0] go_snb
);

    localparam int SNB_W = $clog2(SPB);
    localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

    typedef struct packed {
        logic             lock;
        key_st_e          kst;
        logic             ser;
        logic [1:0]       psize;
        logic [SNB_W-1:0] snb;
        logic [CNT_W-1:0] cnt;
        logic             go;
        err_flags_t       err;
    } bank_st_t;

    bank_st_t s_d, s_q;

    logic             w_ser;
    logic [1:0]       w_ps;
    logic [SNB_W-1:0] w_snb;
    logic             w_start;

    assign w_ser   = wdata[CB_SER];
    assign w_ps    = wdata[CB_PS_LO +: 2];
    assign w_snb   = wdata[CB_SN_LO +: SNB_W];
    assign w_start = wdata[CB_START];

    always_comb begin
        s_d    = s_q;
        s_d.go = 1'b0;
        if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;

        // ordered two-word unlock
        if (key_we && s_q.lock) begin
            unique case (s_q.kst)
                KS_IDLE: s_d.kst = (wdata == KEY_FIRST) ? KS_HALF : KS_DEAD;
                KS_HALF: begin
                    if (wdata == KEY_SECOND) begin
                        s_d.lock = 1'b0;
                        s_d.kst  = KS_IDLE;
                    end else begin
                        s_d.kst = KS_DEAD;
                    end
                end
                default: s_d.kst = KS_DEAD;
            endcase
        end

        if (ctrl_we) begin
            if (s_q.lock) begin
                if (w_start) s_d.err.seq = 1'b1;
            end else begin
                s_d.lock  = wdata[CB_LOCK];
                s_d.ser   = w_ser;
                s_d.psize = w_ps;
                s_d.snb   = w_snb;
                if (w_start) begin
                    if (s_q.cnt != '0 || !w_ser) begin
                        s_d.err.seq = 1'b1;
                    end else if (w_ps == 2'd0) begin
                        s_d.err.par = 1'b1;
                    end else if (WP_BITS[w_snb]) begin
                        s_d.err.wp = 1'b1;
                    end else begin
                        s_d.cnt = CNT_W'(ERASE_CYCLES);
                        s_d.go  = 1'b1;
                    end
                end
            end
        end

        if (clr_we && wdata == '1) s_d.err = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.lock  <= 1'b1;
            s_q.kst   <= KS_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    err_code_e code;

    flc_err_prio u_prio (
        .flags (s_q.err),
        .code  (code)
    );

    assign busy   = (s_q.cnt != '0);
    assign go     = s_q.go;
    assign go_snb = s_q.snb;

    always_comb begin
        ctrl_rd                      = '0;
        ctrl_rd[CB_LOCK]             = s_q.lock;
        ctrl_rd[CB_SER]              = s_q.ser;
        ctrl_rd[CB_PS_LO +: 2]       = s_q.psize;
        ctrl_rd[CB_SN_LO +: SNB_W]   = s_q.snb;
        stat_rd                      = '0;
        stat_rd[SB_BUSY]             = busy;
        stat_rd[SB_SEQ]              = s_q.err.seq;
        stat_rd[SB_PAR]              = s_q.err.par;
        stat_rd[SB_WP]               = s_q.err.wp;
        stat_rd[SB_CODE_LO +: 2]     = code;
    end

    // R2: locked control writes change nothing
    a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && s_q.lock) |=> (s_q.lock && s_q.ser == $past(s_q.ser)
            && s_q.psize == $past(s_q.psize) && s_q.snb == $past(s_q.snb)));

    // R3: the lock only drops after the first key was seen
    a_r3_unlock_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.lock) |-> ($past(s_q.kst) == KS_HALF));

    // R4: a broken sequence stays broken
    a_r4_dead_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.kst == KS_DEAD) |=> (s_q.kst == KS_DEAD));

    // R6: a launch loads the full erase window
    a_r6_launch_load: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.go |-> (s_q.cnt == CNT_W'(ERASE_CYCLES)));

    // R8: start while busy is refused and flagged
    a_r8_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && w_start && s_q.cnt != '0) |=> (!s_q.go && s_q.err.seq));

    // R12: all-ones clear empties the flags
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && wdata == '1) |=> (s_q.err == '0));

endmodule

// File: rtl/flc_keyed_regs.sv
module flc_keyed_regs
    import flc_pkg::*;
#(
    parameter int                 SPB          = 8,
    parameter int                 ERASE_CYCLES = 20,
    parameter logic [2*SPB-1:0]   WP_MASK      = 16'h4080
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic [2:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic [1:0]               bank_busy,
    output logic                     erase_go,
    output logic [$clog2(SPB):0]     erase_sec
);

    localparam int NB    = 2;
    localparam int SNB_W = $clog2(SPB);

    logic [31:0]      ctrl_v [NB];
    logic [31:0]      stat_v [NB];
    logic [NB-1:0]    go_v;
    logic [SNB_W-1:0] snb_v  [NB];

    logic       bank_sel;
    logic [1:0] reg_sel;

    assign bank_sel = bus_addr[2];
    assign reg_sel  = bus_addr[1:0];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        assign hit = bus_we && (bank_sel == 1'(b));

        flc_bank #(
            .SPB          (SPB),
            .ERASE_CYCLES (ERASE_CYCLES),
            .WP_BITS      (WP_MASK[b*SPB +: SPB])
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .key_we  (hit && reg_sel == 2'd0),
            .ctrl_we (hit && reg_sel == 2'd1),
            .clr_we  (hit && reg_sel == 2'd3),
            .wdata   (bus_wdata),
            .ctrl_rd (ctrl_v[b]),
            .stat_rd (stat_v[b]),
            .busy    (bank_busy[b]),
            .go      (go_v[b]),
            .go_snb  (snb_v[b])
        );
    end

    always_comb begin
        unique case (reg_sel)
            2'd1:    bus_rdata = ctrl_v[bank_sel];
            2'd2:    bus_rdata = stat_v[bank_sel];
            default: bus_rdata = '0;
        endcase
    end

    assign erase_go = |go_v;

    always_comb begin
        if (go_v[1])      erase_sec = {1'b1, snb_v[1]};
        else if (go_v[0]) erase_sec = {1'b0, snb_v[0]};
        else              erase_sec = '0;
    end

    // R6: only one bank can launch in a cycle
    a_r6_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go_v));

endmodule

// File: tb/tb_flc_keyed_regs.sv
module tb_flc_keyed_regs;

    localparam int CLK_P   = 10;
    localparam int ERASE_N = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  bank_busy;
    logic        erase_go;
    logic [3:0]  erase_sec;

    always #(CLK_P/2) clk = ~clk;

    flc_keyed_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bank_busy(bank_busy),
        .erase_go(erase_go), .erase_sec(erase_sec)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // behavioural reference model
    int m_lock[2], m_kst[2], m_ser[2], m_ps[2], m_snb[2], m_cnt[2], m_go[2];
    bit m_wp[2], m_par[2], m_seq[2];

    function automatic bit is_protected(int g);
        return (g == 7) || (g == 14);
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 2; b++) begin
            m_lock[b] = 1; m_kst[b] = 0; m_ser[b] = 0; m_ps[b] = 0;
            m_snb[b] = 0; m_cnt[b] = 0; m_go[b] = 0;
            m_wp[b] = 0; m_par[b] = 0; m_seq[b] = 0;
        end
    endtask

    task automatic model_step();
        int b, r;
        logic [31:0] d;
        for (int k = 0; k < 2; k++) begin
            m_go[k] = 0;
            if (m_cnt[k] > 0) m_cnt[k]--;
        end
        if (!bus_we) return;
        b = int'(bus_addr[2]);
        r = int'(bus_addr[1:0]);
        d = bus_wdata;
        if (r == 0 && m_lock[b] == 1) begin
            if (m_kst[b] == 0) m_kst[b] = (d == 32'h45670123) ? 1 : 2;
            else if (m_kst[b] == 1) begin
                if (d == 32'hCDEF89AB) begin m_lock[b] = 0; m_kst[b] = 0; end
                else m_kst[b] = 2;
            end
        end else if (r == 1) begin
            if (m_lock[b] == 1) begin
                if (d[2]) m_seq[b] = 1;
            end else begin
                m_lock[b] = int'(d[0]); m_ser[b] = int'(d[1]);
                m_ps[b] = int'(d[5:4]); m_snb[b] = int'(d[10:8]);
                if (d[2]) begin
                    if (m_cnt[b] > 0 || !d[1]) m_seq[b] = 1;
                    else if (d[5:4] == 0) m_par[b] = 1;
                    else if (is_protected(b*8 + m_snb[b])) m_wp[b] = 1;
                    else begin m_cnt[b] = ERASE_N; m_go[b] = 1; end
                end
            end
        end else if (r == 3 && d == 32'hFFFF_FFFF) begin
            m_wp[b] = 0; m_par[b] = 0; m_seq[b] = 0;
        end
    endtask

    function automatic logic [31:0] exp_ctrl(int b);
        return 32'(m_lock[b] | (m_ser[b] << 1) | (m_ps[b] << 4) | (m_snb[b] << 8));
    endfunction

    function automatic logic [31:0] exp_stat(int b);
        int code;
        code = m_wp[b] ? 1 : m_par[b] ? 2 : m_seq[b] ? 3 : 0;
        return 32'((m_cnt[b] > 0) | (m_seq[b] << 1) | (m_par[b] << 2)
                   | (m_wp[b] << 3) | (code << 8));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // per-cycle compare of the launch and busy outputs (R6)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [3:0] es;
            es = m_go[1] ? 4'(8 + m_snb[1]) : m_go[0] ? 4'(m_snb[0]) : 4'd0;
            chk("R6 busy", {30'd0, bank_busy}, {30'd0, m_cnt[1] > 0, m_cnt[0] > 0});
            chk("R6 go", {31'd0, erase_go}, {31'd0, (m_go[0] | m_go[1]) != 0});
            chk("R6 sector", {28'd0, erase_sec}, {28'd0, es});
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic unlock(logic [2:0] key_a);
        wr(key_a, 32'h45670123);
        wr(key_a, 32'hCDEF89AB);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog (all requirements) got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        rd("R1 ctrl0", 3'd1, 32'h1);
        rd("R1 ctrl1", 3'd5, 32'h1);
        rd("R1 stat0", 3'd2, 32'h0);
        rd("R1 stat1", 3'd6, 32'h0);

        // R2 locked write ignored
        wr(3'd1, 32'h0000_0322);
        rd("R2 ctrl0 locked", 3'd1, 32'h1);
        // R8 start on locked bank
        wr(3'd1, 32'h0000_0326);
        rd("R8 locked start", 3'd2, 32'h302);
        rd("R8 model", 3'd2, exp_stat(0));
        // R12 non-matching clear keeps flags, all ones clears
        wr(3'd3, 32'h0000_1234);
        rd("R12 partial clear", 3'd2, 32'h302);
        wr(3'd3, 32'hFFFF_FFFF);
        rd("R12 full clear", 3'd2, 32'h0);

        // R3 unlock bank 0 only
        unlock(3'd0);
        rd("R3 ctrl0 unlocked", 3'd1, 32'h0);
        rd("R3 ctrl1 still locked", 3'd5, 32'h1);

        // R4 reversed keys kill bank 1 until reset
        wr(3'd4, 32'hCDEF89AB);
        wr(3'd4, 32'h45670123);
        rd("R4 reversed", 3'd5, 32'h1);
        unlock(3'd4);
        rd("R4 sticky", 3'd5, 32'h1);

        // R9 zero parallelism
        wr(3'd1, 32'h0000_0306);
        rd("R9 par flag", 3'd2, 32'h204);
        wr(3'd3, 32'hFFFF_FFFF);
        // R8 erase-select clear
        wr(3'd1, 32'h0000_0324);
        rd("R8 no ser", 3'd2, 32'h302);
        wr(3'd3, 32'hFFFF_FFFF);
        // R10 protected sector 7
        wr(3'd1, 32'h0000_0726);
        rd("R10 wp flag", 3'd2, 32'h108);
        // R11 stack par and seq on top of wp
        wr(3'd1, 32'h0000_0306);
        wr(3'd1, 32'h0000_0324);
        rd("R11 all flags", 3'd2, 32'h10E);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0000_0324);
        wr(3'd1, 32'h0000_0306);
        rd("R11 par over seq", 3'd2, 32'h206);
        wr(3'd3, 32'hFFFF_FFFF);
        rd("R12 cleared", 3'd2, 32'h0);

        // R6 valid erase on sector 3
        wr(3'd1, 32'h0000_0326);
        rd("R6 busy status", 3'd2, 32'h1);
        // R8 start while busy
        wr(3'd1, 32'h0000_0326);
        rd("R8 busy start", 3'd2, exp_stat(0));
        chk("R8 busy start seq", exp_stat(0) & 32'h2, 32'h2);
        repeat (ERASE_N + 2) @(negedge clk);
        rd("R6 idle after", 3'd2, 32'h302);
        // R7 erase-select persists
        rd("R7 ser kept", 3'd1, 32'h322);
        wr(3'd1, 32'h0000_0320);
        rd("R7 ser cleared", 3'd1, 32'h320);
        wr(3'd3, 32'hFFFF_FFFF);

        // R5 relock and unlock again
        wr(3'd1, 32'h0000_0001);
        rd("R5 relocked", 3'd1, 32'h1);
        unlock(3'd0);
        rd("R5 unlocked again", 3'd1, 32'h0);

        // second reset: R4 recovers, R6 bank 2 routing
        do_reset();
        rd("R1 ctrl1 after reset", 3'd5, 32'h1);
        unlock(3'd4);
        rd("R4 reset recovers", 3'd5, 32'h0);
        wr(3'd5, 32'h0000_0526);
        chk("R6 bank2 launch seen", {31'd0, bank_busy[1]}, 32'h1);
        repeat (ERASE_N + 2) @(negedge clk);
        rd("R7 bank2 ser kept", 3'd5, 32'h522);
        rd("R6 bank2 idle", 3'd6, 32'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule